// File: doc/BRIEF.md
# Register-pair and immediate subtract unit

This block holds a small file of 16-bit registers and runs two kinds of subtract on it, each updating one shared carry flag. The pair subtract joins two registers into a 32-bit word, with the even-numbered register as the upper half and the next register as the lower half. It takes one such word from another, writes the 32-bit result back across the destination pair and sets carry when a borrow occurs. The immediate subtract removes a short constant (1 to 16) from one register. It forms the result by adding the two's complement of the constant with one extra bit of width, and it sets carry from the carry-out of that addition. So after an immediate subtract, carry means "no borrow". After a pair subtract, carry means "borrow".

One operation is presented per cycle on plain control pins. The block accepts every cycle and never applies back-pressure, so there is no ready signal. An operation is taken on the rising edge where `instr_valid` is high. Its register writes and its carry update land on that same edge. On the following cycle a commit report shows what was written. A separate load port seeds registers, and an observation read port shows any register at once.

Top module: `rsu_sub_unit`

## Requirements
- R1: While `rst_n` is low and after it is released, every register reads 0, `carry` is 0, and `commit_valid` and `op_illegal` are 0.
- R2: With `op_sel`=0 (pair subtract), the minuend is {reg[dst_idx], reg[dst_idx+1]} and the subtrahend is {reg[src_idx], reg[src_idx+1]}, with the even register in bits 31:16. The difference modulo 2^32 is written with bits 31:16 to reg[dst_idx] and bits 15:0 to reg[dst_idx+1].
- R3: After a pair subtract, `carry` is 1 exactly when the unsigned minuend is smaller than the unsigned subtrahend.
- R4: With `op_sel`=1 (immediate subtract), `imm_field` values 1..15 mean themselves and 0 means 16. reg[dst_idx] receives the low 16 bits of reg[dst_idx] plus the 16-bit negation of that constant. `src_idx` is not used.
- R5: After an immediate subtract, `carry` is bit 16 of that 17-bit sum, which is 1 exactly when the register value is at least the constant.
- R6: Writes and the carry update take effect on the rising edge where `instr_valid` is 1. With `instr_valid` at 0, no register and no carry change through the operation path.
- R7: A pair subtract with an odd `dst_idx` or an odd `src_idx` is illegal. It writes no register, leaves `carry` unchanged, gives no commit report, and raises `op_illegal` for the next cycle.
- R8: With `ld_en`=1 and `instr_valid`=0, reg[ld_idx] takes `ld_data` on the rising edge. With `instr_valid`=1, the load is ignored.
- R9: In the cycle after an accepted operation, `commit_valid`=1 with `commit_idx`=dst_idx and `commit_hi` equal to the value written to dst_idx. For a pair subtract, `commit_pair`=1 and `commit_lo` is the value written to dst_idx+1. For an immediate subtract, `commit_pair`=0 and `commit_lo`=0. In any other cycle, `commit_valid` is 0.
- R10: `obs_data` shows reg[obs_idx] combinationally, reflecting the writes of the last rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Operation present this cycle |
| op_sel | input | 1 | 0 pair subtract, 1 immediate subtract |
| dst_idx | input | 4 | Destination register (pair: even upper register) |
| src_idx | input | 4 | Subtrahend pair upper register (pair only) |
| imm_field | input | 4 | Immediate constant, 0 encodes 16 |
| ld_en | input | 1 | Load port enable |
| ld_idx | input | 4 | Load port register index |
| ld_data | input | 16 | Load port data |
| obs_idx | input | 4 | Observation read index |
| obs_data | output | 16 | Observation read data |
| carry | output | 1 | Carry flag |
| commit_valid | output | 1 | Previous cycle's operation was written |
| commit_pair | output | 1 | Reported write covered a register pair |
| commit_idx | output | 4 | Reported destination index |
| commit_hi | output | 16 | Value written to the destination register |
| commit_lo | output | 16 | Value written to the next register (pair) or 0 |
| op_illegal | output | 1 | Previous cycle's operation was rejected |

## Verification
The pair subtract is tried with equal operands, which must give zero and no carry. It is also tried with a smaller minuend, which must wrap and set carry, and with a borrow that crosses from the lower half into the upper half. These three patterns separate a correct 32-bit borrow from per-half arithmetic and from an inverted flag. The immediate subtract is tried with the register equal to, below and above the constant, and with field 0 against register values 3 and 16. This exposes a wrong zero-means-16 decode and a carry taken in the borrow sense. Random mixes of both operations, of odd indices, of idle cycles and of loads that collide with operations then check the gating, the write targets and the ignored paths against a bench model.

// File: rtl/rsu_pkg.sv
package rsu_pkg;
  typedef enum logic {
    OP_PAIR_SUB = 1'b0,
    OP_IMM_SUB  = 1'b1
  } rsu_op_e;
endpackage

// File: rtl/rsu_regfile.sv
// Register file: two operation write ports, one load port, NRD async read ports.
module rsu_regfile #(
  parameter int DATA_W = 16,
  parameter int NREGS  = 16,
  parameter int NRD    = 5,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wa_en,
  input  logic [IDX_W-1:0]             wa_idx,
  input  logic [DATA_W-1:0]            wa_data,
  input  logic                         wb_en,
  input  logic [IDX_W-1:0]             wb_idx,
  input  logic [DATA_W-1:0]            wb_data,
  input  logic                         ld_en,
  input  logic [IDX_W-1:0]             ld_idx,
  input  logic [DATA_W-1:0]            ld_data,
  input  logic [NRD-1:0][IDX_W-1:0]    rd_idx,
  output logic [NRD-1:0][DATA_W-1:0]   rd_data
);
  logic [DATA_W-1:0] regs [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        regs[g] <= '0;
      end else if (wa_en && wa_idx == IDX_W'(g)) begin
        regs[g] <= wa_data;
      end else if (wb_en && wb_idx == IDX_W'(g)) begin
        regs[g] <= wb_data;
      end else if (ld_en && ld_idx == IDX_W'(g)) begin
        regs[g] <= ld_data;
      end
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rd_data[r] = regs[rd_idx[r]];
  end

  // The two operation ports never aim at the same register, and the load never overlaps them
  assert property (@(posedge clk) disable iff (!rst_n)
    (wa_en && wb_en) |-> (wa_idx != wb_idx))
    else $error("assert_ports_disjoint_R2");
  assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |-> !wa_en)
    else $error("assert_load_blocked_R8");
endmodule

// File: rtl/rsu_pair_sub.sv
// 32-bit subtract of two register pairs; carry as borrow.
module rsu_pair_sub #(
  parameter int DATA_W = 16,
  localparam int PAIR_W = 2 * DATA_W
) (
  input  logic [DATA_W-1:0] a_hi,
  input  logic [DATA_W-1:0] a_lo,
  input  logic [DATA_W-1:0] b_hi,
  input  logic [DATA_W-1:0] b_lo,
  output logic [DATA_W-1:0] diff_hi,
  output logic [DATA_W-1:0] diff_lo,
  output logic              borrow
);
  logic [PAIR_W-1:0] a_w, b_w;
  logic [PAIR_W:0]   diff_ext;

  always_comb begin
    a_w      = {a_hi, a_lo};
    b_w      = {b_hi, b_lo};
    diff_ext = {1'b0, a_w} - {1'b0, b_w};
    diff_hi  = diff_ext[PAIR_W-1:DATA_W];
    diff_lo  = diff_ext[DATA_W-1:0];
    borrow   = diff_ext[PAIR_W];
  end

  always_comb begin
    if (!$isunknown({a_hi, a_lo, b_hi, b_lo})) begin
      assert (borrow == ({a_hi, a_lo} < {b_hi, b_lo}))
        else $error("assert_borrow_is_less_R3");
    end
  end
endmodule

// File: rtl/rsu_imm_sub.sv
// Register minus short immediate via negated addition; carry is the carry-out.
module rsu_imm_sub #(
  parameter int DATA_W = 16,
  parameter int IMM_W  = 4
) (
  input  logic [DATA_W-1:0] val,
  input  logic [IMM_W-1:0]  imm_field,
  output logic [DATA_W-1:0] res,
  output logic              carry_out
);
  localparam logic [DATA_W-1:0] ZERO_MEANS = DATA_W'(1) << IMM_W;

  logic [DATA_W-1:0] eff_imm, neg_imm;
  logic [DATA_W:0]   sum;

  always_comb begin
    eff_imm   = (imm_field == '0) ? ZERO_MEANS : DATA_W'(imm_field);
    neg_imm   = ~eff_imm + DATA_W'(1);
    sum       = {1'b0, val} + {1'b0, neg_imm};
    res       = sum[DATA_W-1:0];
    carry_out = sum[DATA_W];
  end

  always_comb begin
    if (!$isunknown({val, imm_field})) begin
      assert (eff_imm != '0 && eff_imm <= ZERO_MEANS)
        else $error("assert_imm_range_R4");
      assert (carry_out == (val >= eff_imm))
        else $error("assert_carry_no_borrow_R5");
    end
  end
endmodule

// File: rtl/rsu_sub_unit.sv
module rsu_sub_unit #(
  parameter int DATA_W = 16,
  parameter int NREGS  = 16,
  parameter int IMM_W  = 4,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  input  logic              op_sel,
  input  logic [IDX_W-1:0]  dst_idx,
  input  logic [IDX_W-1:0]  src_idx,
  input  logic [IMM_W-1:0]  imm_field,
  input  logic              ld_en,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [IDX_W-1:0]  obs_idx,
  output logic [DATA_W-1:0] obs_data,
  output logic              carry,
  output logic              commit_valid,
  output logic              commit_pair,
  output logic [IDX_W-1:0]  commit_idx,
  output logic [DATA_W-1:0] commit_hi,
  output logic [DATA_W-1:0] commit_lo,
  output logic              op_illegal
);
  import rsu_pkg::*;

  localparam int NRD = 5;
  localparam int RD_DH = 0, RD_DL = 1, RD_SH = 2, RD_SL = 3, RD_OBS = 4;

  rsu_op_e op;
  logic is_pair, illegal_now, accept, ld_eff;
  logic [IDX_W-1:0] dst_lo_idx, src_lo_idx;
  logic [NRD-1:0][IDX_W-1:0]  rd_idx;
  logic [NRD-1:0][DATA_W-1:0] rd_data;
  logic [DATA_W-1:0] p_hi, p_lo, i_res;
  logic p_borrow, i_carry;
  logic wa_en, wb_en;
  logic [DATA_W-1:0] wa_data;
  logic carry_d;

  always_comb begin
    op          = rsu_op_e'(op_sel);
    is_pair     = (op == OP_PAIR_SUB);
    dst_lo_idx  = {dst_idx[IDX_W-1:1], 1'b1};
    src_lo_idx  = {src_idx[IDX_W-1:1], 1'b1};
    illegal_now = instr_valid && is_pair && (dst_idx[0] || src_idx[0]);
    accept      = instr_valid && !illegal_now;
    ld_eff      = ld_en && !instr_valid;
    wa_en       = accept;
    wb_en       = accept && is_pair;
    wa_data     = is_pair ? p_hi : i_res;
    carry_d     = accept ? (is_pair ? p_borrow : i_carry) : carry;
  end

  always_comb begin
    rd_idx[RD_DH]  = dst_idx;
    rd_idx[RD_DL]  = dst_lo_idx;
    rd_idx[RD_SH]  = src_idx;
    rd_idx[RD_SL]  = src_lo_idx;
    rd_idx[RD_OBS] = obs_idx;
  end

  assign obs_data = rd_data[RD_OBS];

  rsu_regfile #(.DATA_W(DATA_W), .NREGS(NREGS), .NRD(NRD)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .wa_en(wa_en), .wa_idx(dst_idx), .wa_data(wa_data),
    .wb_en(wb_en), .wb_idx(dst_lo_idx), .wb_data(p_lo),
    .ld_en(ld_eff), .ld_idx(ld_idx), .ld_data(ld_data),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  rsu_pair_sub #(.DATA_W(DATA_W)) u_pair (
    .a_hi(rd_data[RD_DH]), .a_lo(rd_data[RD_DL]),
    .b_hi(rd_data[RD_SH]), .b_lo(rd_data[RD_SL]),
    .diff_hi(p_hi), .diff_lo(p_lo), .borrow(p_borrow)
  );

  rsu_imm_sub #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_imm (
    .val(rd_data[RD_DH]), .imm_field(imm_field),
    .res(i_res), .carry_out(i_carry)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      carry        <= 1'b0;
      commit_valid <= 1'b0;
      commit_pair  <= 1'b0;
      commit_idx   <= '0;
      commit_hi    <= '0;
      commit_lo    <= '0;
      op_illegal   <= 1'b0;
    end else begin
      carry        <= carry_d;
      commit_valid <= accept;
      op_illegal   <= illegal_now;
      if (accept) begin
        commit_pair <= is_pair;
        commit_idx  <= dst_idx;
        commit_hi   <= wa_data;
        commit_lo   <= is_pair ? p_lo : '0;
      end
    end
  end

  assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> $stable(carry))
    else $error("assert_carry_hold_idle_R6");
  assert property (@(posedge clk) disable iff (!rst_n)
    illegal_now |=> (op_illegal && !commit_valid && $stable(carry)))
    else $error("assert_illegal_no_effect_R7");
  assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && !illegal_now) |=> commit_valid)
    else $error("assert_commit_follows_R9");
  assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && commit_pair) |-> !commit_idx[0])
    else $error("assert_pair_even_R7");
  assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && !commit_pair) |-> (commit_lo == '0))
    else $error("assert_imm_lo_zero_R9");
endmodule

// File: tb/test_rsu_sub_unit.sv
module test_rsu_sub_unit;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 16;
  localparam int N  = 16;
  localparam int IW = 4;
  localparam int XW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic instr_valid = 1'b0, op_sel = 1'b0;
  logic [XW-1:0] dst_idx = '0, src_idx = '0, ld_idx = '0, obs_idx = '0;
  logic [IW-1:0] imm_field = '0;
  logic ld_en = 1'b0;
  logic [W-1:0] ld_data = '0;
  logic [W-1:0] obs_data, commit_hi, commit_lo;
  logic carry, commit_valid, commit_pair, op_illegal;
  logic [XW-1:0] commit_idx;

  int checks = 0, fails = 0;
  logic [W-1:0] m_regs [N];
  logic m_carry;

  always #(CLK_PERIOD/2) clk = ~clk;

  rsu_sub_unit i_rsu_sub_unit (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .op_sel(op_sel),
    .dst_idx(dst_idx), .src_idx(src_idx), .imm_field(imm_field),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
    .obs_idx(obs_idx), .obs_data(obs_data), .carry(carry),
    .commit_valid(commit_valid), .commit_pair(commit_pair), .commit_idx(commit_idx),
    .commit_hi(commit_hi), .commit_lo(commit_lo), .op_illegal(op_illegal)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [32:0] exp_pair(logic [31:0] a, logic [31:0] b);
    return {a < b, a - b};
  endfunction

  function automatic logic [16:0] exp_imm(logic [15:0] v, logic [3:0] f);
    logic [15:0] e = (f == 0) ? 16'd16 : {12'd0, f};
    return {1'b0, v} + {1'b0, (~e + 16'd1)};
  endfunction

  task automatic rd(input logic [XW-1:0] i, output logic [W-1:0] d);
    obs_idx = i;
    #1;
    d = obs_data;
  endtask

  task automatic check_all(string req);
    logic [W-1:0] d;
    for (int i = 0; i < N; i++) begin
      rd(XW'(i), d);
      chk(req, $sformatf("reg%0d", i), {16'd0, d}, {16'd0, m_regs[i]});
    end
    chk(req, "carry", {31'd0, carry}, {31'd0, m_carry});
  endtask

  task automatic load(logic [XW-1:0] i, logic [W-1:0] v);
    @(negedge clk);
    ld_en = 1'b1; ld_idx = i; ld_data = v;
    @(negedge clk);
    ld_en = 1'b0;
    m_regs[i] = v;
  endtask

  // Issue one operation; optional colliding load. Checks commit, flags and written regs.
  task automatic issue(logic v, logic op, logic [XW-1:0] d, logic [XW-1:0] s,
                       logic [IW-1:0] f, logic coll_ld);
    logic ill, acc;
    logic [32:0] pr;
    logic [16:0] ir;
    logic [W-1:0] ehi, elo, got;
    logic [XW-1:0] d1, lidx;
    lidx = XW'($urandom_range(0, N-1));
    d1 = {d[XW-1:1], 1'b1};
    ill = v && !op && (d[0] || s[0]);
    acc = v && !ill;
    pr = exp_pair({m_regs[d], m_regs[d1]}, {m_regs[s], m_regs[{s[XW-1:1], 1'b1}]});
    ir = exp_imm(m_regs[d], f);
    @(negedge clk);
    instr_valid = v; op_sel = op; dst_idx = d; src_idx = s; imm_field = f;
    ld_en = coll_ld; ld_idx = lidx; ld_data = 16'hBEEF;
    @(negedge clk);
    instr_valid = 1'b0; ld_en = 1'b0;
    if (acc) begin
      if (!op) begin
        ehi = pr[31:16]; elo = pr[15:0];
        m_regs[d] = ehi; m_regs[d1] = elo; m_carry = pr[32];
      end else begin
        ehi = ir[15:0]; elo = '0;
        m_regs[d] = ehi; m_carry = ir[16];
      end
    end else if (!v && coll_ld) begin
      m_regs[lidx] = 16'hBEEF;
    end
    chk(ill ? "R7" : "R9", "commit_valid", {31'd0, commit_valid}, {31'd0, acc});
    chk("R7", "op_illegal", {31'd0, op_illegal}, {31'd0, ill});
    chk(op ? "R5" : "R3", "carry", {31'd0, carry}, {31'd0, m_carry});
    if (acc) begin
      chk("R9", "commit_pair", {31'd0, commit_pair}, {31'd0, !op});
      chk("R9", "commit_idx", {28'd0, commit_idx}, {28'd0, d});
      chk(op ? "R4" : "R2", "commit_hi", {16'd0, commit_hi}, {16'd0, ehi});
      chk("R9", "commit_lo", {16'd0, commit_lo}, {16'd0, elo});
      rd(d, got);
      chk(op ? "R4" : "R2", "dst reg", {16'd0, got}, {16'd0, m_regs[d]});
      if (!op) begin
        rd(d1, got);
        chk("R2", "dst+1 reg", {16'd0, got}, {16'd0, m_regs[d1]});
      end
    end
    if (coll_ld) begin
      rd(lidx, got);
      chk("R8", "load target", {16'd0, got}, {16'd0, m_regs[lidx]});
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] d;
    void'($urandom(32'h1A2B3C4D));
    for (int i = 0; i < N; i++) m_regs[i] = '0;
    m_carry = 1'b0;
    repeat (3) @(negedge clk);
    // R1: state during and after reset
    chk("R1", "carry in reset", {31'd0, carry}, 32'd0);
    chk("R1", "commit_valid in reset", {31'd0, commit_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "op_illegal", {31'd0, op_illegal}, 32'd0);
    check_all("R1");

    // R8/R10: loads visible on observation port
    load(4'd0, 16'h0001); load(4'd1, 16'h0000);
    load(4'd2, 16'h0000); load(4'd3, 16'h0001);
    rd(4'd0, d); chk("R10", "obs after load", {16'd0, d}, 32'h1);

    // R2/R3: borrow crosses the half boundary, no overall borrow
    issue(1, 0, 4'd0, 4'd2, 0, 0);
    chk("R2", "cross-half hi", {16'd0, m_regs[0]}, 32'h0000);
    chk("R2", "cross-half lo", {16'd0, m_regs[1]}, 32'hFFFF);
    // R3: equal pair -> zero, carry 0
    issue(1, 0, 4'd4, 4'd4, 0, 0);
    chk("R3", "equal carry", {31'd0, carry}, 32'd0);
    // R3: smaller minuend wraps and sets carry
    load(4'd6, 16'h0000); load(4'd7, 16'h0005);
    load(4'd8, 16'h0000); load(4'd9, 16'h0009);
    issue(1, 0, 4'd6, 4'd8, 0, 0);
    chk("R3", "wrap carry", {31'd0, carry}, 32'd1);
    chk("R2", "wrap lo", {16'd0, m_regs[7]}, 32'hFFFC);

    // R4/R5: immediate corners
    load(4'd10, 16'd5);  issue(1, 1, 4'd10, 4'd3, 4'd5, 0);
    chk("R5", "equal imm carry", {31'd0, carry}, 32'd1);
    load(4'd10, 16'd3);  issue(1, 1, 4'd10, 4'd0, 4'd0, 0);
    chk("R4", "field0 is 16", {16'd0, m_regs[10]}, 32'hFFF3);
    chk("R5", "below imm carry", {31'd0, carry}, 32'd0);
    load(4'd11, 16'd16); issue(1, 1, 4'd11, 4'd0, 4'd0, 0);
    chk("R4", "16-16", {16'd0, m_regs[11]}, 32'd0);
    load(4'd11, 16'd0);  issue(1, 1, 4'd11, 4'd0, 4'd1, 0);
    chk("R5", "0-1 carry", {31'd0, carry}, 32'd0);
    issue(1, 1, 4'd11, 4'd0, 4'd15, 0); // odd dst legal for immediate

    // R7: odd indices rejected; R6: idle cycle; R8: load ignored under an op
    issue(1, 0, 4'd3, 4'd2, 0, 0);
    issue(1, 0, 4'd2, 4'd5, 0, 0);
    check_all("R7");
    issue(0, 0, 4'd0, 4'd2, 0, 0);
    issue(0, 1, 4'd0, 4'd2, 4'd1, 0);
    check_all("R6");
    issue(1, 1, 4'd12, 4'd0, 4'd2, 1);
    check_all("R8");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic v, op, cl;
      v  = ($urandom_range(0, 7) != 0);
      op = $urandom_range(0, 1) == 1;
      cl = ($urandom_range(0, 4) == 0);
      if ($urandom_range(0, 5) == 0) load(XW'($urandom_range(0, N-1)), W'($urandom));
      issue(v, op, XW'($urandom_range(0, N-1)), XW'($urandom_range(0, N-1)),
            IW'($urandom_range(0, 15)), cl);
      if (n % 80 == 79) check_all("R6");
    end
    check_all("R10");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule